// File: doc/BRIEF.md
# Galois LFSR Interval Counter

This block measures out programmable intervals of tick-enable cycles. An 11-bit Galois linear-feedback shift register does the counting in place of a binary down-counter. Software, or a neighbouring block, turns a coarse interval length into the matching register state and loads that state. From then on, each enabled tick advances the register by one Galois step. When the register reaches the all-ones terminal state, the next enabled tick reloads the programmed state and emits a one-cycle terminal pulse. The intervals therefore repeat with no gap between them.

A shift register has a shallower next-state path than a binary decrementer with zero detection, so it suits a fast clock. The cost is that the interval value has to be translated into a register state. That translation lives outside the block. The all-zero state is a lock-up state of the register, and the block uses it to mean "stopped".

Top module: `lfsr_interval_counter`

## Requirements
- R1: After reset the counter is idle: `tcPulse` is low and stays low while `tickEn` is held high and nothing is loaded.
- R2: One step maps state s to (s >> 1), and when bit 0 of s is 1 the result is also XORed with 0x500 (11-bit state). This step is a maximal-length sequence of period 2047 over the nonzero states.
- R3: For coarse value i (1 to 2047), the loaded state is the state reached 2048−i steps after 0x7FF. With `tickEn` held high, the first `tcPulse` appears exactly i cycles after the clock edge that takes the load.
- R4: The terminal state is 0x7FF. A tick taken in the terminal state reloads the programmed state on the same edge, so later pulses repeat every i ticks with no gap.
- R5: `tcPulse` is registered. It is high for the single cycle after each terminal tick, so it is low between pulses when i > 1.
- R6: While `tickEn` is low the state is frozen, which delays the next pulse by exactly the number of cycles without a tick.
- R7: Loading state 0 stops the counter: no pulse occurs, however long ticks continue, including when 0 is loaded in the middle of a running interval.
- R8: `loadStb` takes priority over a tick in the same cycle. A load in the middle of an interval discards the old interval and starts the new one from the load edge.
- R9: Coarse value 1 (state 0x7FF) gives a pulse on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStb | input | 1 | Load strobe: captures `loadVal` as both the current and the reload state |
| loadVal | input | 11 | Register state that encodes the interval (0 means stopped) |
| tickEn | input | 1 | Advance by one step in this cycle |
| tcPulse | output | 1 | Terminal-count pulse, one cycle per finished interval |

## Verification
The bench builds the block with its default 11-bit width and tap mask 0x500, so the whole 2047-state cycle is in play. It builds its own table of forward states by stepping from 0x7FF. It then sweeps every coarse value from 1 to 48, a stride of values across the rest of the range, and the end points 2046 and 2047. For each value it measures the latency from load to first pulse and the steady period. Directed cases cover tick gaps, loads that land in the middle of an interval, zero loads and the every-tick case.

// File: rtl/lfsr_ivl_pkg.sv
package lfsr_ivl_pkg;
  // Strobes from control to datapath; at most one acts per cycle (load wins)
  typedef struct packed {
    logic load;
    logic step;
    logic reload;
  } ivlStrobe_t;
endpackage

// File: rtl/lfsr_ivl_dp.sv
module lfsr_ivl_dp
  import lfsr_ivl_pkg::*;
#(
  parameter int unsigned STATE_W = 11,
  parameter logic [STATE_W-1:0] TAP_MASK = 11'h500
) (
  input  logic               clk,
  input  logic               rstN,
  input  ivlStrobe_t         strobe,
  input  logic [STATE_W-1:0] loadVal,
  output logic               atTerm,
  output logic               isZero
);
  localparam logic [STATE_W-1:0] TERM_STATE = {STATE_W{1'b1}};

  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] reloadQ;
  logic [STATE_W-1:0] stateNext;

  // Galois step: shift right, fold the outgoing bit into the tap positions
  for (genvar b = 0; b < STATE_W; b++) begin : g_step
    if (b == STATE_W - 1) begin : g_top
      assign stateNext[b] = TAP_MASK[b] & stateQ[0];
    end else begin : g_mid
      assign stateNext[b] = stateQ[b+1] ^ (TAP_MASK[b] & stateQ[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= '0;
      reloadQ <= '0;
    end else if (strobe.load) begin
      stateQ  <= loadVal;
      reloadQ <= loadVal;
    end else if (strobe.reload) begin
      stateQ  <= reloadQ;
    end else if (strobe.step) begin
      stateQ  <= stateNext;
    end
  end

  assign atTerm = (stateQ == TERM_STATE);
  assign isZero = (stateQ == '0);

  // R2: stepping never falls into the lock-up state
  p_step_nonzero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && !isZero) |=> !isZero);

  // R4: a terminal reload restores the programmed state
  p_reload_restores_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.reload && !strobe.load) |=> (stateQ == $past(reloadQ)));

  // R6: with no strobe the state is frozen
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step && !strobe.reload) |=> $stable(stateQ));

  // R7: the zero state stays put until a new load
  p_zero_sticks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isZero && !strobe.load) |=> isZero);
endmodule

// File: rtl/lfsr_ivl_ctrl.sv
module lfsr_ivl_ctrl
  import lfsr_ivl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStb,
  input  logic       tickEn,
  input  logic       atTerm,
  input  logic       isZero,
  output ivlStrobe_t strobe,
  output logic       tcPulse
);
  always_comb begin
    strobe.load   = loadStb;
    strobe.reload = !loadStb && tickEn && atTerm;
    strobe.step   = !loadStb && tickEn && !atTerm && !isZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) tcPulse <= 1'b0;
    else       tcPulse <= strobe.reload;
  end

  // R8: a load cycle never ends an interval
  p_load_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> !tcPulse);

  // R7: a stopped counter never pulses
  p_idle_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isZero && !loadStb) |=> !tcPulse);

  // R6: no tick, no pulse
  p_no_tick_no_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> !tcPulse);

  // R2: step and reload are mutually exclusive
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.step && strobe.reload));
endmodule

// File: rtl/lfsr_interval_counter.sv
module lfsr_interval_counter
  import lfsr_ivl_pkg::*;
#(
  parameter int unsigned STATE_W = 11,
  parameter logic [STATE_W-1:0] TAP_MASK = 11'h500
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadStb,
  input  logic [STATE_W-1:0] loadVal,
  input  logic               tickEn,
  output logic               tcPulse
);
  ivlStrobe_t strobe;
  logic       atTerm;
  logic       isZero;

  lfsr_ivl_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadStb (loadStb),
    .tickEn  (tickEn),
    .atTerm  (atTerm),
    .isZero  (isZero),
    .strobe  (strobe),
    .tcPulse (tcPulse)
  );

  lfsr_ivl_dp #(
    .STATE_W  (STATE_W),
    .TAP_MASK (TAP_MASK)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .loadVal (loadVal),
    .atTerm  (atTerm),
    .isZero  (isZero)
  );

  // R1: output quiet in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> !tcPulse);
endmodule

// File: tb/lfsr_interval_counter_tb.sv
module lfsr_interval_counter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStb = 1'b0;
  logic [10:0] loadVal = '0;
  logic        tickEn = 1'b0;
  logic        tcPulse;

  int testsRun = 0;
  int testsFailed = 0;
  int cycleCount = 0;
  bit finished = 1'b0;
  logic [10:0] fwd [0:2047];

  always #5 clk = ~clk;

  lfsr_interval_counter u_dut (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .loadVal(loadVal),
    .tickEn(tickEn), .tcPulse(tcPulse)
  );

  function automatic logic [10:0] stepFn(logic [10:0] s);
    return (s >> 1) ^ (s[0] ? 11'h500 : 11'h000);
  endfunction

  task automatic check(string req, int actual, int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic doLoad(logic [10:0] v);
    @(negedge clk); loadStb = 1'b1; loadVal = v;
    @(negedge clk); loadStb = 1'b0;
  endtask

  // counts samples until a pulse; returns limit+1 on timeout
  task automatic waitPulse(int limit, output int n);
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!tcPulse && n <= limit);
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 190000 && !finished) begin
      finished = 1'b1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cycleCount);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int n;
    int seen;
    logic [10:0] st = 11'h7FF;
    for (int k = 2047; k >= 1; k--) begin
      st = stepFn(st);
      fwd[k] = st;
    end
    fwd[0] = '0;
    // R2: model sequence closes after 2047 steps
    check("R2 period", int'(fwd[1]), 'h7FF);

    repeat (3) @(negedge clk);
    check("R1 reset", int'(tcPulse), 0);
    rstN = 1'b1; tickEn = 1'b1;
    seen = 0;
    repeat (200) begin @(negedge clk); if (tcPulse) seen++; end
    check("R1 idle", seen, 0);

    // R3 R4 sweep
    for (int i = 1; i <= 2047; i++) begin
      if (i <= 48 || (i % 61) == 0 || i >= 2046) begin
        doLoad(fwd[i]);
        waitPulse(i + 4, n);
        check($sformatf("R3 latency i=%0d", i), n, i);
        waitPulse(i + 4, n);
        check($sformatf("R4 period i=%0d", i), n, i);
      end
    end

    // R9: every tick
    doLoad(fwd[1]);
    seen = 0;
    repeat (20) begin @(negedge clk); if (tcPulse) seen++; end
    check("R9 every tick", seen, 20);

    // R5: single-cycle pulse
    doLoad(fwd[3]);
    waitPulse(8, n);
    @(negedge clk);
    check("R5 width", int'(tcPulse), 0);

    // R6: tick gap delays pulse
    doLoad(fwd[10]);
    tickEn = 1'b0;
    seen = 0;
    repeat (5) begin @(negedge clk); if (tcPulse) seen++; end
    tickEn = 1'b1;
    check("R6 no pulse while frozen", seen, 0);
    waitPulse(20, n);
    check("R6 delayed latency", n + 5, 15);

    // R8: reload mid-interval
    doLoad(fwd[100]);
    repeat (30) @(negedge clk);
    doLoad(fwd[7]);
    waitPulse(110, n);
    check("R8 mid-interval reload", n, 7);

    // R7: zero load mid-run, then long run
    doLoad(fwd[5]);
    repeat (3) @(negedge clk);
    doLoad(11'h000);
    seen = 0;
    repeat (3000) begin @(negedge clk); if (tcPulse) seen++; end
    check("R7 zero stops", seen, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule